// File: doc/BRIEF.md
# Remote Terminal Busy Resolver

This block works out the Busy bit of a remote terminal's status reply for each command that arrives, along with what that decision means for the data words. Three sources can make the terminal busy. The first is a global control in the host configuration, which is active low and applies only to commands addressed to this terminal alone. The second is a host-written table of 128 single-bit entries, one for each broadcast/own, direction and subaddress combination. The third is a busy state that is set at reset when the auto-boot pin is high.

The result is latched one clock after a command strobe. The resolver sets three outputs: the busy bit, a flag that stops data words from being sent on a transmit command, and an enable for writing received data words to memory. For a busy receive command that is not a mode code, a host option chooses whether the data words are kept or thrown away. A mode-code receive command always keeps its data word.

Top module: `rt_busy_resolver`

## Requirements
- R1: During reset and on the first cycle after it, rsp_valid, rsp_busy, rsp_no_tx_data and rsp_store_rx are 0. Reset sets the global control to 1 (not busy), sets the receive-while-busy option to 0 (discard) and clears every table entry.
- R2: A command strobe sampled at a clock edge gives rsp_valid = 1 for exactly the following cycle. In cycles without a strobe, rsp_valid is 0 and the other three outputs keep their last values.
- R3: When the stored global control is 0, every command with cmd_bcast = 0 is busy. A command with cmd_bcast = 1 is not made busy by the global control.
- R4: The table index is {cmd_bcast, cmd_tr, cmd_subaddr}, with bit 6 = broadcast, bit 5 = transmit and bits 4:0 = subaddress. A stored 1 at that index makes the command busy, and other indices are unaffected.
- R5: If auto-boot is high during reset, every command is busy, broadcast ones included, until the first configuration write. That write clears the auto-boot state.
- R6: For a transmit command (cmd_tr = 1), rsp_no_tx_data equals rsp_busy and rsp_store_rx is 0.
- R7: For a busy receive command that is not a mode code, rsp_store_rx equals the stored receive-while-busy option (1 = store). A receive command that is not busy always stores.
- R8: A receive command with cmd_mode = 1 always gives rsp_store_rx = 1, and for any receive command rsp_no_tx_data is 0.
- R9: A configuration or table write in the same cycle as a strobe does not affect that command. It takes effect from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| autoboot_en | input | 1 | Auto-boot pin, sampled while in reset |
| cfg_wr | input | 1 | Host configuration write strobe |
| cfg_busy_n | input | 1 | Global busy control, active low |
| cfg_store_busy | input | 1 | Receive-while-busy option, 1 = store data |
| tbl_wr | input | 1 | Table entry write strobe |
| tbl_idx | input | 7 | Table entry index {bcast, tr, subaddr} |
| tbl_bit | input | 1 | Table entry value, 1 = busy |
| cmd_stb | input | 1 | Command strobe |
| cmd_bcast | input | 1 | Command is broadcast |
| cmd_tr | input | 1 | 1 = transmit, 0 = receive |
| cmd_subaddr | input | 5 | Command subaddress |
| cmd_mode | input | 1 | Command is a mode code |
| rsp_valid | output | 1 | Result valid, one cycle after the strobe |
| rsp_busy | output | 1 | Busy bit for the status reply |
| rsp_no_tx_data | output | 1 | Do not send data words |
| rsp_store_rx | output | 1 | Write received data words to memory |

## Verification
The resolver is driven with random commands over all 128 index values while the global control, the option and the table entries are also written at random. This shows whether each source of busy is applied with the right broadcast gating and the right index bit order. Directed sequences cover the cases that random stimulus reaches only rarely. One is auto-boot against the first configuration write, which separates boot busy from global busy on broadcast commands. Another is a write to the table entry next to a busy one, which catches an index that is off by one or has its fields swapped. The rest are a mode-code receive while busy, which shows whether the store option is wrongly applied to mode codes, and writes that land in the same cycle as a strobe, which show whether the command uses the old or the new settings.

// File: rtl/rtb_pkg.sv
// Shared types for the busy resolver.
package rtb_pkg;
    // Host configuration image: global busy control and receive-while-busy option
    typedef struct packed {
        logic busy_n;       // global busy, active low
        logic store_busy;   // 1 = keep data words of a busy receive
    } rtb_cfg_t;
endpackage

// File: rtl/rtb_cfg.sv
// Host configuration register and auto-boot busy state.
// Assumes autoboot_en is steady while rst_n is low; the boot state is cleared
// by the first configuration write.
module rtb_cfg
    import rtb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     autoboot_en,
    input  logic     cfg_wr,
    input  logic     cfg_busy_n,
    input  logic     cfg_store_busy,
    output rtb_cfg_t cfg_q,
    output logic     boot_busy
);
    // Load the configuration on a host write; load the boot state while in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.busy_n     <= 1'b1;
            cfg_q.store_busy <= 1'b0;
            boot_busy        <= autoboot_en;
        end else if (cfg_wr) begin
            cfg_q.busy_n     <= cfg_busy_n;
            cfg_q.store_busy <= cfg_store_busy;
            boot_busy        <= 1'b0;
        end
    end
endmodule

// File: rtl/rtb_lut.sv
// Per-command busy table, one bit for each {bcast, tr, subaddr} index.
// Assumes a single write port; reads are combinational and return the old
// contents when a write happens in the same cycle.
module rtb_lut #(
    parameter int IDX_W = 7,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);
    logic [DEPTH-1:0] mem_q;

    // Clear every entry in reset, otherwise write the addressed entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_bit;
        end
    end

    // Look up the entry for the current command
    always_comb rd_bit = mem_q[rd_idx];
endmodule

// File: rtl/rtb_decide.sv
// Merges the busy sources and registers the response flags one clock after the
// strobe. Between strobes the flags hold their values and valid drops.
module rtb_decide
    import rtb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cmd_stb,
    input  logic     cmd_bcast,
    input  logic     cmd_tr,
    input  logic     cmd_mode,
    input  rtb_cfg_t cfg_q,
    input  logic     boot_busy,
    input  logic     tbl_hit,
    output logic     rsp_valid,
    output logic     rsp_busy,
    output logic     rsp_no_tx_data,
    output logic     rsp_store_rx
);
    logic busy_d;
    logic store_d;

    // Busy is the OR of the gated global control, the table entry and the boot state
    always_comb busy_d = (!cfg_q.busy_n && !cmd_bcast) || tbl_hit || boot_busy;

    // Receive data is kept when idle, for mode codes, or when the option says so
    always_comb store_d = !cmd_tr && (!busy_d || cmd_mode || cfg_q.store_busy);

    // Capture the response on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_busy       <= 1'b0;
            rsp_no_tx_data <= 1'b0;
            rsp_store_rx   <= 1'b0;
        end else begin
            rsp_valid <= cmd_stb;
            if (cmd_stb) begin
                rsp_busy       <= busy_d;
                rsp_no_tx_data <= busy_d && cmd_tr;
                rsp_store_rx   <= store_d;
            end
        end
    end
endmodule

// File: rtl/rt_busy_resolver.sv
// Top level of the busy resolver: configuration, per-command table and the
// registered decision. Assumes the command fields are valid with cmd_stb.
module rt_busy_resolver
    import rtb_pkg::*;
#(
    parameter int SA_W = 5,
    localparam int IDX_W = SA_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             autoboot_en,
    input  logic             cfg_wr,
    input  logic             cfg_busy_n,
    input  logic             cfg_store_busy,
    input  logic             tbl_wr,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic             tbl_bit,
    input  logic             cmd_stb,
    input  logic             cmd_bcast,
    input  logic             cmd_tr,
    input  logic [SA_W-1:0]  cmd_subaddr,
    input  logic             cmd_mode,
    output logic             rsp_valid,
    output logic             rsp_busy,
    output logic             rsp_no_tx_data,
    output logic             rsp_store_rx
);
    rtb_cfg_t         cfg_q;
    logic             boot_busy;
    logic             tbl_hit;
    logic [IDX_W-1:0] cmd_idx;

    // Table index: broadcast on top, then direction, then subaddress
    always_comb cmd_idx = {cmd_bcast, cmd_tr, cmd_subaddr};

    rtb_cfg u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .autoboot_en    (autoboot_en),
        .cfg_wr         (cfg_wr),
        .cfg_busy_n     (cfg_busy_n),
        .cfg_store_busy (cfg_store_busy),
        .cfg_q          (cfg_q),
        .boot_busy      (boot_busy)
    );

    rtb_lut #(.IDX_W(IDX_W)) u_lut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr),
        .wr_idx (tbl_idx),
        .wr_bit (tbl_bit),
        .rd_idx (cmd_idx),
        .rd_bit (tbl_hit)
    );

    rtb_decide u_dec (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_stb        (cmd_stb),
        .cmd_bcast      (cmd_bcast),
        .cmd_tr         (cmd_tr),
        .cmd_mode       (cmd_mode),
        .cfg_q          (cfg_q),
        .boot_busy      (boot_busy),
        .tbl_hit        (tbl_hit),
        .rsp_valid      (rsp_valid),
        .rsp_busy       (rsp_busy),
        .rsp_no_tx_data (rsp_no_tx_data),
        .rsp_store_rx   (rsp_store_rx)
    );
endmodule

// File: rtl/rtb_checker.sv
// Port-level properties of the busy resolver, bound to every instance of the top.
module rtb_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_stb,
    input logic cmd_tr,
    input logic cmd_mode,
    input logic rsp_valid,
    input logic rsp_busy,
    input logic rsp_no_tx_data,
    input logic rsp_store_rx
);
    // R2
    valid_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> rsp_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> !rsp_valid);
    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> ($stable(rsp_busy) && $stable(rsp_no_tx_data) && $stable(rsp_store_rx)));
    // R6
    tx_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_tr) |=> (rsp_no_tx_data == rsp_busy) && !rsp_store_rx);
    // R8
    rx_mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !cmd_tr && cmd_mode) |=> rsp_store_rx && !rsp_no_tx_data);
    // R7
    rx_idle_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_busy && !rsp_no_tx_data) |-> (rsp_store_rx || $past(cmd_tr)));
endmodule

bind rt_busy_resolver rtb_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_stb        (cmd_stb),
    .cmd_tr         (cmd_tr),
    .cmd_mode       (cmd_mode),
    .rsp_valid      (rsp_valid),
    .rsp_busy       (rsp_busy),
    .rsp_no_tx_data (rsp_no_tx_data),
    .rsp_store_rx   (rsp_store_rx)
);

// File: tb/rt_busy_resolver_bench.sv
// Self-checking bench: a reference model built from the requirements, with
// seeded random traffic and directed corner cases.
module rt_busy_resolver_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       autoboot_en = 1'b0;
    logic       cfg_wr = 1'b0, cfg_busy_n = 1'b1, cfg_store_busy = 1'b0;
    logic       tbl_wr = 1'b0;
    logic [6:0] tbl_idx = '0;
    logic       tbl_bit = 1'b0;
    logic       cmd_stb = 1'b0, cmd_bcast = 1'b0, cmd_tr = 1'b0, cmd_mode = 1'b0;
    logic [4:0] cmd_subaddr = '0;
    logic       rsp_valid, rsp_busy, rsp_no_tx_data, rsp_store_rx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference model state
    bit         m_gbn, m_swb, m_boot;
    bit [127:0] m_tbl;
    bit         e_busy, e_notx, e_store;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_busy_resolver u_rt_busy_resolver (
        .clk(clk), .rst_n(rst_n), .autoboot_en(autoboot_en),
        .cfg_wr(cfg_wr), .cfg_busy_n(cfg_busy_n), .cfg_store_busy(cfg_store_busy),
        .tbl_wr(tbl_wr), .tbl_idx(tbl_idx), .tbl_bit(tbl_bit),
        .cmd_stb(cmd_stb), .cmd_bcast(cmd_bcast), .cmd_tr(cmd_tr),
        .cmd_subaddr(cmd_subaddr), .cmd_mode(cmd_mode),
        .rsp_valid(rsp_valid), .rsp_busy(rsp_busy),
        .rsp_no_tx_data(rsp_no_tx_data), .rsp_store_rx(rsp_store_rx)
    );

    function automatic bit ref_busy(bit b, bit tr, bit [4:0] sa);
        return (!m_gbn && !b) || m_tbl[{b, tr, sa}] || m_boot;
    endfunction

    function automatic bit ref_store(bit busy, bit tr, bit md);
        return !tr && (!busy || md || m_swb);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reset with the given auto-boot level, then check the reset state (R1)
    task automatic do_reset(bit ab);
        @(negedge clk);
        rst_n = 1'b0; autoboot_en = ab;
        cmd_stb = 0; cfg_wr = 0; tbl_wr = 0;
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", rsp_valid, 0);
        chk("R1", "busy in reset", rsp_busy, 0);
        rst_n = 1'b1;
        m_gbn = 1; m_swb = 0; m_boot = ab; m_tbl = '0;
        e_busy = 0; e_notx = 0; e_store = 0;
        @(negedge clk);
        chk("R1", "valid after reset", rsp_valid, 0);
        chk("R1", "busy after reset", rsp_busy, 0);
        chk("R1", "notx after reset", rsp_no_tx_data, 0);
        chk("R1", "store after reset", rsp_store_rx, 0);
    endtask

    // One cycle of stimulus; the command sees the model as it was before the edge (R9)
    task automatic step(string req, bit stb, bit b, bit tr, bit [4:0] sa, bit md,
                        bit cw, bit gbn, bit swb, bit tw, bit [6:0] ti, bit tb);
        cmd_stb = stb; cmd_bcast = b; cmd_tr = tr; cmd_subaddr = sa; cmd_mode = md;
        cfg_wr = cw; cfg_busy_n = gbn; cfg_store_busy = swb;
        tbl_wr = tw; tbl_idx = ti; tbl_bit = tb;
        if (stb) begin
            e_busy  = ref_busy(b, tr, sa);
            e_notx  = e_busy && tr;
            e_store = ref_store(e_busy, tr, md);
        end
        @(posedge clk);
        if (cw) begin m_gbn = gbn; m_swb = swb; m_boot = 0; end
        if (tw) m_tbl[ti] = tb;
        @(negedge clk);
        cmd_stb = 0; cfg_wr = 0; tbl_wr = 0;
        chk(stb ? "R2" : "R2", "valid", rsp_valid, int'(stb));
        chk(req, "busy", rsp_busy, e_busy);
        chk(req, "no_tx_data", rsp_no_tx_data, e_notx);
        chk(req, "store_rx", rsp_store_rx, e_store);
    endtask

    task automatic cmd(string req, bit b, bit tr, bit [4:0] sa, bit md);
        step(req, 1, b, tr, sa, md, 0, 1, 0, 0, '0, 0);
    endtask

    task automatic cfg(bit gbn, bit swb);
        step("R2", 0, 0, 0, '0, 0, 1, gbn, swb, 0, '0, 0);
    endtask

    task automatic tbl(bit [6:0] ti, bit tb);
        step("R2", 0, 0, 0, '0, 0, 0, 1, 0, 1, ti, tb);
    endtask

    initial begin
        void'($urandom(1234));
        // R5: auto-boot busy, broadcast included, until first config write
        do_reset(1);
        cmd("R5", 1, 0, 5'd3, 0);
        cmd("R5", 0, 1, 5'd9, 0);
        cfg(1, 0);
        cmd("R5", 1, 0, 5'd3, 0);
        // R1: a table that was not written is clear
        cmd("R1", 0, 1, 5'd31, 0);
        // R3: global busy applies to own-address only
        cfg(0, 0);
        cmd("R3", 0, 0, 5'd4, 0);
        cmd("R3", 1, 0, 5'd4, 0);
        cmd("R3", 1, 1, 5'd4, 0);
        // R6: busy transmit stops data
        cmd("R6", 0, 1, 5'd7, 0);
        // R7: receive-while-busy option off, then on
        cmd("R7", 0, 0, 5'd7, 0);
        cfg(0, 1);
        cmd("R7", 0, 0, 5'd7, 0);
        cfg(0, 0);
        // R8: mode-code receive stores even when busy and discarding
        cmd("R8", 0, 0, 5'd0, 1);
        // R2: idle cycles hold the last result
        step("R2", 0, 0, 0, '0, 0, 0, 1, 0, 0, '0, 0);
        step("R2", 0, 0, 0, '0, 0, 0, 1, 0, 0, '0, 0);
        // R4: a single table entry, neighbours unaffected
        cfg(1, 0);
        tbl(7'b1_1_11111, 1);
        cmd("R4", 1, 1, 5'd31, 0);
        cmd("R4", 1, 1, 5'd30, 0);
        cmd("R4", 0, 1, 5'd31, 0);
        cmd("R4", 1, 0, 5'd31, 0);
        tbl(7'b0_0_00001, 1);
        cmd("R4", 0, 0, 5'd1, 0);
        cmd("R4", 0, 0, 5'd0, 0);
        // R9: same-edge writes do not affect the command in flight
        step("R9", 1, 0, 0, 5'd2, 0, 1, 0, 0, 0, '0, 0);
        cmd("R9", 0, 0, 5'd2, 0);
        step("R9", 1, 1, 0, 5'd5, 0, 0, 1, 0, 1, 7'b1_0_00101, 1);
        cmd("R9", 1, 0, 5'd5, 0);
        // R1: a second reset without auto-boot clears the table
        do_reset(0);
        cmd("R1", 1, 1, 5'd31, 0);
        cmd("R1", 0, 0, 5'd1, 0);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] r;
            r = $urandom;
            step("R4", r[0] | r[1], r[2], r[3], r[8:4], r[9],
                 (r[15:12] == 4'd0), r[16], r[17],
                 (r[20:18] == 3'd0), r[27:21], r[28] | r[29]);
        end
        summary();
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end
endmodule